// File: doc/BRIEF.md
# Burst Stream Source Guard

This block sits between user logic and a multi-lane streaming transmitter. Each clock the user side may offer one word of 64 bits per lane, qualified by a valid bit. The same cycle may carry start-of-burst and end-of-burst marks and an 8-bit sync byte. The guard accepts traffic only while the link is up. It queues accepted words in a small first-word-fall-through buffer that the transmit side drains with a pop request.

On an accepted start mark it keeps the sync byte, and on an accepted end mark it keeps the sync byte too. The end-of-burst byte is read as the number of unused 64-bit lanes in the closing word. The guard polices the framing: the idle spacing between a burst end and the next burst start, ordering of the marks, range of the unused-lane count, and buffer overflow. Faults are reported as sticky flags that only a user reset clears.

A parameter selects continuous mode. In that mode the whole stream is one burst and the spacing rule does not apply.

Top module: `strm_burst_guard`

## Requirements
- R1: After `rstUser` the buffer is empty (`bufLevel`=0, `outValid`=0), all error flags and held sync values are zero, and `ready` equals `linkUp` AND NOT `bufFull`.
- R2: A word is accepted when `inValid` and `linkUp` are both 1 and the buffer is not full. Words leave on `outData` in arrival order, the oldest shown while `outValid` is 1, and `popReq` removes it at the clock edge.
- R3: A valid word offered while `bufLevel` equals DEPTH is dropped, and `errVec[0]` becomes 1 at that edge, even if a pop happens in the same cycle.
- R4: An accepted start mark stores `inSync` in `sobSyncHeld`. An accepted end mark stores `inSync` unchanged in `eobSyncHeld`. Marks count only on cycles with `inValid` and `linkUp` both 1.
- R5: On an accepted end mark, `eobInvalid` takes `inSync` when it is at most LANES-1. Otherwise it takes LANES-1 and `protoErr` becomes 1. With one lane, any nonzero value is a violation.
- R6: In burst mode, the number of idle cycles strictly between an accepted end mark and the next accepted start mark must equal GAP. Otherwise `errVec[3]` becomes 1. The first start after reset is not checked.
- R7: A start mark while a burst is open, or an end mark while none is open, sets `seqErr` and is ignored: no held value changes and the burst state stays. A start and an end in the same cycle with no burst open form a one-word burst.
- R8: In continuous mode (CONT=1) only the first start mark after reset is accepted. Any later start mark sets `seqErr`, and the spacing rule is never applied.
- R9: `errVec[1]` and `errVec[2]` (memory-upset indications) are always 0.
- R10: `errVec[0]`, `errVec[3]`, `protoErr` and `seqErr` stay 1 until `rstUser`, and `rstUser` empties the buffer.
- R11: While `linkUp` is 0, words, marks and sync values are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | User-side clock |
| rstUser | input | 1 | Synchronous active-high reset, clears buffer and flags |
| linkUp | input | 1 | Link ready; gates all acceptance |
| inData | input | 64*LANES | Word of 64 bits per lane |
| inValid | input | 1 | inData qualifier |
| inSob | input | 1 | Start-of-burst mark |
| inEob | input | 1 | End-of-burst mark |
| inSync | input | 8 | Sync byte sampled on marks |
| popReq | input | 1 | Remove the oldest buffered word |
| ready | output | 1 | Link up and buffer has room |
| outData | output | 64*LANES | Oldest buffered word |
| outValid | output | 1 | Buffer holds at least one word |
| bufFull | output | 1 | Buffer holds DEPTH words |
| bufLevel | output | $clog2(DEPTH+1) | Buffer occupancy |
| sobSyncHeld | output | 8 | Sync byte of last accepted start |
| eobSyncHeld | output | 8 | Raw sync byte of last accepted end |
| eobInvalid | output | 8 | Clamped unused-lane count of last end |
| errVec | output | 4 | {gap fault, 0, 0, overflow}, sticky |
| protoErr | output | 1 | Unused-lane count out of range, sticky |
| seqErr | output | 1 | Misordered mark, sticky |

## Verification
The assertions watch, on every cycle, that an offer into a full buffer raises the overflow flag, and that the sticky flags never fall without reset. They also check that occupancy stays within DEPTH, that the stored unused-lane count never exceeds LANES-1, and that nothing moves while the link is down. Only the directed scenarios can show the rest. Those are the order of data through the buffer, the exact idle count that passes or fails the spacing rule, the ignored misordered marks leaving held sync values untouched, the clamp value, and the single accepted start in continuous mode.

// File: rtl/sbg_pkg.sv
package sbg_pkg;
  localparam int WORD_W = 64;
  localparam int SYNC_W = 8;

  // Strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic push;      // write inData into the buffer
    logic capSob;    // hold sync byte of an accepted start
    logic capEob;    // hold sync byte of an accepted end
    logic clampEob;  // unused-lane count out of range, store LANES-1
  } sbgStrobe_t;
endpackage

// File: rtl/sbg_ctrl.sv
module sbg_ctrl
  import sbg_pkg::*;
#(
  parameter int LANES = 2,
  parameter int GAP   = 4,
  parameter bit CONT  = 1'b0
) (
  input  logic              clk,
  input  logic              rstUser,
  input  logic              linkUp,
  input  logic              inValid,
  input  logic              inSob,
  input  logic              inEob,
  input  logic [SYNC_W-1:0] inSync,
  input  logic              bufFull,
  output sbgStrobe_t        strobe,
  output logic              ovfErr,
  output logic              gapErr,
  output logic              protoErr,
  output logic              seqErr
);
  localparam int GAP_W = $clog2(GAP + 2);
  localparam logic [GAP_W-1:0] GAP_VAL = GAP_W'(GAP);
  localparam logic [GAP_W-1:0] GAP_SAT = GAP_W'(GAP + 1);
  localparam logic [SYNC_W-1:0] MAX_INV = SYNC_W'(LANES - 1);

  logic burstOpen, started, haveEob;
  logic [GAP_W-1:0] gapCnt;

  logic take, sobReq, eobReq, sobAllowed, sobOk, sobBad;
  logic openAfterSob, eobOk, eobBad, gapMiss, invBad;

  assign take   = inValid & linkUp;
  assign sobReq = take & inSob;
  assign eobReq = take & inEob;

  generate
    if (CONT) begin : g_cont
      assign sobAllowed = ~started;
    end else begin : g_burst
      assign sobAllowed = 1'b1;
    end
  endgenerate

  assign sobOk        = sobReq & ~burstOpen & sobAllowed;
  assign sobBad       = sobReq & ~sobOk;
  assign openAfterSob = burstOpen | sobOk;
  assign eobOk        = eobReq & openAfterSob;
  assign eobBad       = eobReq & ~openAfterSob;
  assign gapMiss      = sobOk & haveEob & ~CONT & (gapCnt != GAP_VAL);
  assign invBad       = eobOk & (inSync > MAX_INV);

  always_comb begin
    strobe.push     = take & ~bufFull;
    strobe.capSob   = sobOk;
    strobe.capEob   = eobOk;
    strobe.clampEob = invBad;
  end

  always_ff @(posedge clk) begin
    if (rstUser) begin
      burstOpen <= 1'b0;
      started   <= 1'b0;
      haveEob   <= 1'b0;
      gapCnt    <= '0;
      ovfErr    <= 1'b0;
      gapErr    <= 1'b0;
      protoErr  <= 1'b0;
      seqErr    <= 1'b0;
    end else begin
      burstOpen <= eobOk ? 1'b0 : openAfterSob;
      started   <= started | sobOk;
      if (eobOk)      haveEob <= 1'b1;
      else if (sobOk) haveEob <= 1'b0;
      if (eobOk)                 gapCnt <= '0;
      else if (gapCnt != GAP_SAT) gapCnt <= gapCnt + 1'b1;
      ovfErr   <= ovfErr | (take & bufFull);
      gapErr   <= gapErr | gapMiss;
      protoErr <= protoErr | invBad;
      seqErr   <= seqErr | sobBad | eobBad;
    end
  end
endmodule

// File: rtl/sbg_datapath.sv
module sbg_datapath
  import sbg_pkg::*;
#(
  parameter int LANES = 2,
  parameter int DEPTH = 16
) (
  input  logic                      clk,
  input  logic                      rstUser,
  input  sbgStrobe_t                strobe,
  input  logic [LANES*WORD_W-1:0]   inData,
  input  logic [SYNC_W-1:0]         inSync,
  input  logic                      popReq,
  output logic                      bufFull,
  output logic [$clog2(DEPTH+1)-1:0] level,
  output logic [LANES*WORD_W-1:0]   outData,
  output logic                      outValid,
  output logic [SYNC_W-1:0]         sobSyncHeld,
  output logic [SYNC_W-1:0]         eobSyncHeld,
  output logic [SYNC_W-1:0]         eobInvalid
);
  localparam int DW    = LANES * WORD_W;
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic doPop;

  assign doPop    = popReq & (level != '0);
  assign bufFull  = (level == FULL_CNT);
  assign outValid = (level != '0);
  assign outData  = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (strobe.push) mem[wrPtr] <= inData;
  end

  always_ff @(posedge clk) begin
    if (rstUser) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (strobe.push) wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
      if (doPop)       rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
      case ({strobe.push, doPop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rstUser) begin
      sobSyncHeld <= '0;
      eobSyncHeld <= '0;
      eobInvalid  <= '0;
    end else begin
      if (strobe.capSob) sobSyncHeld <= inSync;
      if (strobe.capEob) begin
        eobSyncHeld <= inSync;
        eobInvalid  <= strobe.clampEob ? SYNC_W'(LANES - 1) : inSync;
      end
    end
  end
endmodule

// File: rtl/strm_burst_guard.sv
module strm_burst_guard
  import sbg_pkg::*;
#(
  parameter int LANES = 2,
  parameter int DEPTH = 16,
  parameter int GAP   = 4,
  parameter bit CONT  = 1'b0
) (
  input  logic                       clk,
  input  logic                       rstUser,
  input  logic                       linkUp,
  input  logic [LANES*64-1:0]        inData,
  input  logic                       inValid,
  input  logic                       inSob,
  input  logic                       inEob,
  input  logic [7:0]                 inSync,
  input  logic                       popReq,
  output logic                       ready,
  output logic [LANES*64-1:0]        outData,
  output logic                       outValid,
  output logic                       bufFull,
  output logic [$clog2(DEPTH+1)-1:0] bufLevel,
  output logic [7:0]                 sobSyncHeld,
  output logic [7:0]                 eobSyncHeld,
  output logic [7:0]                 eobInvalid,
  output logic [3:0]                 errVec,
  output logic                       protoErr,
  output logic                       seqErr
);
  sbgStrobe_t strobe;
  logic ovfErr, gapErr;

  sbg_ctrl #(.LANES(LANES), .GAP(GAP), .CONT(CONT)) u_ctrl (
    .clk(clk), .rstUser(rstUser), .linkUp(linkUp), .inValid(inValid),
    .inSob(inSob), .inEob(inEob), .inSync(inSync), .bufFull(bufFull),
    .strobe(strobe), .ovfErr(ovfErr), .gapErr(gapErr),
    .protoErr(protoErr), .seqErr(seqErr)
  );

  sbg_datapath #(.LANES(LANES), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstUser(rstUser), .strobe(strobe), .inData(inData),
    .inSync(inSync), .popReq(popReq), .bufFull(bufFull), .level(bufLevel),
    .outData(outData), .outValid(outValid), .sobSyncHeld(sobSyncHeld),
    .eobSyncHeld(eobSyncHeld), .eobInvalid(eobInvalid)
  );

  assign ready  = linkUp & ~bufFull;
  assign errVec = {gapErr, 1'b0, 1'b0, ovfErr};
endmodule

// File: rtl/sbg_checker.sv
module sbg_checker #(
  parameter int LANES = 2,
  parameter int DEPTH = 16
) (
  input logic                       clk,
  input logic                       rstUser,
  input logic                       linkUp,
  input logic                       inValid,
  input logic                       popReq,
  input logic                       bufFull,
  input logic [$clog2(DEPTH+1)-1:0] bufLevel,
  input logic [7:0]                 sobSyncHeld,
  input logic [7:0]                 eobSyncHeld,
  input logic [7:0]                 eobInvalid,
  input logic [3:0]                 errVec,
  input logic                       protoErr,
  input logic                       seqErr
);
  // R3
  ovf_set_chk: assert property (@(posedge clk) disable iff (rstUser)
    inValid && linkUp && bufFull |=> errVec[0]);
  // R10
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rstUser)
    errVec[0] |=> errVec[0]);
  // R10
  gap_sticky_chk: assert property (@(posedge clk) disable iff (rstUser)
    errVec[3] |=> errVec[3]);
  // R10
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rstUser)
    protoErr || seqErr |=> $countones({protoErr, seqErr}) >= $countones($past({protoErr, seqErr})));
  // R2
  level_bound_chk: assert property (@(posedge clk) disable iff (rstUser)
    int'(bufLevel) <= DEPTH);
  // R5
  inv_range_chk: assert property (@(posedge clk) disable iff (rstUser)
    int'(eobInvalid) <= LANES - 1);
  // R11
  nolink_hold_chk: assert property (@(posedge clk) disable iff (rstUser)
    !linkUp && !popReq |=> $stable(bufLevel) && $stable(sobSyncHeld) && $stable(eobSyncHeld));
endmodule

bind strm_burst_guard sbg_checker #(.LANES(LANES), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/test_strm_burst_guard.sv
module test_strm_burst_guard;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 2;
  localparam int DEPTH = 16;
  localparam int GAP   = 4;
  localparam int DW    = LANES * 64;
  localparam int LW    = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rstUser = 1'b1;
  logic linkUp = 1'b0;
  logic [DW-1:0] inData = '0;
  logic inValid = 1'b0, inSob = 1'b0, inEob = 1'b0, popReq = 1'b0;
  logic [7:0] inSync = '0;

  logic ready, outValid, bufFull, protoErr, seqErr;
  logic [DW-1:0] outData;
  logic [LW-1:0] bufLevel;
  logic [7:0] sobSyncHeld, eobSyncHeld, eobInvalid;
  logic [3:0] errVec;

  logic cReady, cOutValid, cBufFull, cProtoErr, cSeqErr;
  logic [63:0] cOutData;
  logic [LW-1:0] cBufLevel;
  logic [7:0] cSobSync, cEobSync, cEobInvalid;
  logic [3:0] cErrVec;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  strm_burst_guard #(.LANES(LANES), .DEPTH(DEPTH), .GAP(GAP), .CONT(1'b0)) i_strm_burst_guard (
    .clk(clk), .rstUser(rstUser), .linkUp(linkUp), .inData(inData), .inValid(inValid),
    .inSob(inSob), .inEob(inEob), .inSync(inSync), .popReq(popReq), .ready(ready),
    .outData(outData), .outValid(outValid), .bufFull(bufFull), .bufLevel(bufLevel),
    .sobSyncHeld(sobSyncHeld), .eobSyncHeld(eobSyncHeld), .eobInvalid(eobInvalid),
    .errVec(errVec), .protoErr(protoErr), .seqErr(seqErr));

  strm_burst_guard #(.LANES(1), .DEPTH(DEPTH), .GAP(GAP), .CONT(1'b1)) i_strm_burst_guard_cont (
    .clk(clk), .rstUser(rstUser), .linkUp(linkUp), .inData(inData[63:0]), .inValid(inValid),
    .inSob(inSob), .inEob(inEob), .inSync(inSync), .popReq(popReq), .ready(cReady),
    .outData(cOutData), .outValid(cOutValid), .bufFull(cBufFull), .bufLevel(cBufLevel),
    .sobSyncHeld(cSobSync), .eobSyncHeld(cEobSync), .eobInvalid(cEobInvalid),
    .errVec(cErrVec), .protoErr(cProtoErr), .seqErr(cSeqErr));

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one user cycle; inputs change 1 time unit after an edge
  task automatic cyc(input logic v, input logic s, input logic e, input logic [7:0] sy, input logic [DW-1:0] d);
    inValid = v; inSob = s; inEob = e; inSync = sy; inData = d;
    @(posedge clk); #1;
    inValid = 1'b0; inSob = 1'b0; inEob = 1'b0; inSync = '0; inData = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 1'b0, 8'h0, '0);
  endtask

  task automatic doReset();
    rstUser = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    rstUser = 1'b0;
  endtask

  task automatic popCheck(input logic [DW-1:0] exp, input string req);
    check(outValid === 1'b1, req, DW'(outValid), DW'(1));
    check(outData === exp, req, outData, exp);
    popReq = 1'b1;
    @(posedge clk); #1;
    popReq = 1'b0;
  endtask

  task automatic t_reset();
    doReset();
    check(bufLevel === '0, "R1", DW'(bufLevel), '0);
    check(outValid === 1'b0, "R1", DW'(outValid), '0);
    check({errVec, protoErr, seqErr} === '0, "R1", DW'({errVec, protoErr, seqErr}), '0);
    check({sobSyncHeld, eobSyncHeld, eobInvalid} === '0, "R1", DW'({sobSyncHeld, eobSyncHeld, eobInvalid}), '0);
    check(ready === 1'b0, "R1", DW'(ready), '0);
    linkUp = 1'b1; #1;
    check(ready === 1'b1, "R1", DW'(ready), DW'(1));
  endtask

  task automatic t_link_gate();
    doReset();
    linkUp = 1'b0;
    cyc(1'b1, 1'b1, 1'b0, 8'h5A, {2{64'hAB}});
    cyc(1'b1, 1'b0, 1'b1, 8'h01, {2{64'hCD}});
    check(bufLevel === '0, "R11", DW'(bufLevel), '0);
    check(sobSyncHeld === 8'h0, "R11", DW'(sobSyncHeld), '0);
    check(eobSyncHeld === 8'h0, "R11", DW'(eobSyncHeld), '0);
    check(seqErr === 1'b0, "R11", DW'(seqErr), '0);
    linkUp = 1'b1;
  endtask

  task automatic t_fifo();
    doReset();
    cyc(1'b1, 1'b1, 1'b0, 8'h11, {64'h1, 64'hA1});
    cyc(1'b0, 1'b1, 1'b0, 8'h77, '0); // not valid: no mark
    cyc(1'b1, 1'b0, 1'b0, 8'h99, {64'h2, 64'hA2});
    cyc(1'b1, 1'b0, 1'b1, 8'h01, {64'h3, 64'hA3});
    check(bufLevel === LW'(3), "R2", DW'(bufLevel), DW'(3));
    check(sobSyncHeld === 8'h11, "R4", DW'(sobSyncHeld), DW'(8'h11));
    check(eobSyncHeld === 8'h01, "R4", DW'(eobSyncHeld), DW'(8'h01));
    check(eobInvalid === 8'h01, "R5", DW'(eobInvalid), DW'(1));
    check(protoErr === 1'b0, "R5", DW'(protoErr), '0);
    popCheck({64'h1, 64'hA1}, "R2");
    popCheck({64'h2, 64'hA2}, "R2");
    popCheck({64'h3, 64'hA3}, "R2");
    check(outValid === 1'b0, "R2", DW'(outValid), '0);
  endtask

  task automatic t_gap();
    doReset();
    cyc(1'b1, 1'b1, 1'b1, 8'h0, '0);
    idle(GAP);
    cyc(1'b1, 1'b1, 1'b0, 8'h0, '0);
    check(errVec[3] === 1'b0, "R6 exact gap", DW'(errVec[3]), '0);
    cyc(1'b1, 1'b0, 1'b1, 8'h0, '0);
    idle(GAP - 1);
    cyc(1'b1, 1'b1, 1'b0, 8'h0, '0);
    check(errVec[3] === 1'b1, "R6 short gap", DW'(errVec[3]), DW'(1));
    doReset();
    cyc(1'b1, 1'b1, 1'b1, 8'h0, '0);
    idle(GAP + 1);
    cyc(1'b1, 1'b1, 1'b1, 8'h0, '0);
    check(errVec[3] === 1'b1, "R6 long gap", DW'(errVec[3]), DW'(1));
    idle(3);
    check(errVec[3] === 1'b1, "R10 gap sticky", DW'(errVec[3]), DW'(1));
  endtask

  task automatic t_clamp();
    doReset();
    cyc(1'b1, 1'b1, 1'b0, 8'h0, '0);
    cyc(1'b1, 1'b0, 1'b1, 8'h05, '0);
    check(eobSyncHeld === 8'h05, "R4", DW'(eobSyncHeld), DW'(5));
    check(eobInvalid === 8'h01, "R5 clamp", DW'(eobInvalid), DW'(1));
    check(protoErr === 1'b1, "R5", DW'(protoErr), DW'(1));
  endtask

  task automatic t_order();
    doReset();
    cyc(1'b1, 1'b1, 1'b0, 8'h22, '0);
    cyc(1'b1, 1'b1, 1'b0, 8'h33, '0);
    check(seqErr === 1'b1, "R7 double start", DW'(seqErr), DW'(1));
    check(sobSyncHeld === 8'h22, "R7", DW'(sobSyncHeld), DW'(8'h22));
    doReset();
    cyc(1'b1, 1'b0, 1'b1, 8'h44, '0);
    check(seqErr === 1'b1, "R7 stray end", DW'(seqErr), DW'(1));
    check(eobSyncHeld === 8'h00, "R7", DW'(eobSyncHeld), '0);
    cyc(1'b1, 1'b1, 1'b1, 8'h55, '0);
    check(eobSyncHeld === 8'h55, "R7 one-word burst", DW'(eobSyncHeld), DW'(8'h55));
  endtask

  task automatic t_overflow();
    doReset();
    for (int i = 0; i < DEPTH; i++) cyc(1'b1, 1'b0, 1'b0, 8'h0, {2{64'(i + 100)}});
    check(bufFull === 1'b1, "R3", DW'(bufFull), DW'(1));
    check(ready === 1'b0, "R3", DW'(ready), '0);
    check(errVec[0] === 1'b0, "R3", DW'(errVec[0]), '0);
    cyc(1'b1, 1'b0, 1'b0, 8'h0, {2{64'hDEAD}});
    check(errVec[0] === 1'b1, "R3", DW'(errVec[0]), DW'(1));
    check(bufLevel === LW'(DEPTH), "R3", DW'(bufLevel), DW'(DEPTH));
    for (int i = 0; i < DEPTH; i++) popCheck({2{64'(i + 100)}}, "R3");
    check(bufLevel === '0, "R3", DW'(bufLevel), '0);
    check(errVec[0] === 1'b1, "R10", DW'(errVec[0]), DW'(1));
    check(errVec[2:1] === 2'b00, "R9", DW'(errVec[2:1]), '0);
    cyc(1'b1, 1'b0, 1'b0, 8'h0, {2{64'h7}});
    doReset();
    check(errVec === 4'h0, "R10", DW'(errVec), '0);
    check(bufLevel === '0, "R10", DW'(bufLevel), '0);
  endtask

  task automatic t_cont();
    doReset();
    cyc(1'b1, 1'b1, 1'b0, 8'h07, '0);
    cyc(1'b1, 1'b0, 1'b1, 8'h02, '0);
    check(cProtoErr === 1'b1, "R5 one lane", DW'(cProtoErr), DW'(1));
    check(cEobInvalid === 8'h00, "R5 one lane", DW'(cEobInvalid), '0);
    cyc(1'b1, 1'b1, 1'b0, 8'h09, '0);
    check(cSeqErr === 1'b1, "R8", DW'(cSeqErr), DW'(1));
    check(cSobSync === 8'h07, "R8", DW'(cSobSync), DW'(7));
    check(cErrVec[3] === 1'b0, "R8 no gap rule", DW'(cErrVec[3]), '0);
    check(errVec[3] === 1'b1, "R6 burst mode gap", DW'(errVec[3]), DW'(1));
    check(seqErr === 1'b0, "R8 burst mode", DW'(seqErr), '0);
  endtask

  initial begin
    #1;
    t_reset();
    t_link_gate();
    t_fifo();
    t_gap();
    t_clamp();
    t_order();
    t_overflow();
    t_cont();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    tests++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule